// File: doc/BRIEF.md
# Falling-Edge Manchester Frame Decoder

This block recovers the bits of a Manchester-coded uplink frame (bit period 32 time units, half period 16) using only the spacing between falling edges of an already demodulated input. Time is counted in units given by a one-cycle tick input, one tick per unit. The decoder classifies each interval between falling edges into one of a few length bands. A last-bit register, a skip flag and a start-of-frame discard counter then turn that sequence of bands back into the bit stream. No mid-bit sampling is needed.

A controller pulses `start` when it begins listening for a reply. It selects with `sof_long` how many leading start-of-frame bits are discarded. The block measures the silence before the frame and reports it as the response time. It packs the bits most significant bit first into a byte buffer and strobes `done` once a quiet period shows the frame is over. If nothing decodable arrives within the listen window, it strobes `timeout` instead. The value of the last recovered bit is exported so that a transmitter can lengthen its turnaround wait when that bit was a 1.

Top module: `fe_manchester_rx`

## Requirements
- R1: After reset `busy`, `done`, `timeout` and `bit_count` are 0 and `last_bit` is 1.
- R2: While listening, a falling-edge interval of 80 units or more sets `resp_gap` to that interval minus 16.
- R3: An interval of 57 to 79 units appends the bits 0 then 1.
- R4: An interval of 41 to 56 units appends 0, and then a 1 as well when the skip flag is clear. It then inverts both the skip flag and `last_bit`.
- R5: An interval of 25 to 40 units decrements the start-of-frame counter when it is nonzero, and otherwise appends the current `last_bit`.
- R6: An interval below 25 units appends nothing and changes no state, but it does restart interval measurement.
- R7: `start` begins listening: `last_bit` becomes 1, skip is set, `bit_count` and `resp_gap` are cleared, and the discard counter loads 4 when `sof_long` is 1 or 1 when it is 0.
- R8: Once at least one bit has been appended and 80 units pass with no falling edge, `done` pulses for one cycle and `busy` falls.
- R9: If 300 units pass with no falling edge while no bit has been appended, `timeout` pulses for one cycle and `busy` falls. `done` does not pulse.
- R10: Bit number k of the frame (from 0) is stored at `frame_bytes[8*(k/8) + 7 - k%8]`, so byte i occupies bits [8i+7:8i] with its first bit at bit 7. `bit_count` saturates at MAX_BITS (64) and bits beyond it are dropped.
- R11: `last_bit` exports the last-bit register at all times.
- R12: Intervals count only the cycles in which `t0_tick` is high, so the decode does not depend on the clock-to-unit ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t0_tick | input | 1 | One-cycle pulse per time unit |
| start | input | 1 | Begin a new listen window |
| sof_long | input | 1 | 1: discard 4 start bits, 0: discard 1 |
| rx_in | input | 1 | Demodulated input, decoded on falling edges |
| frame_bytes | output | 64 | Received bits, MSB-first per byte |
| bit_count | output | 7 | Number of stored bits |
| resp_gap | output | 9 | Measured response time in units |
| last_bit | output | 1 | Last-bit register |
| busy | output | 1 | Listen window open |
| done | output | 1 | Frame complete strobe |
| timeout | output | 1 | No-frame strobe |

## Verification
A corrupted skip flag or last-bit register does not show at once. It shows in the first 41-to-56 or 25-to-40 interval after it, as a bit count one too high or low, or an inverted bit. It is then visible on `frame_bytes`, `bit_count` and `last_bit` when `done` fires 80 units later. A wrong discard count shows as a shifted frame or as a timeout where a frame was expected. The bench therefore sweeps every single-interval value after a gap, every three-interval combination of the bit bands in both discard modes, and a saturating long frame, and compares every output at the done or timeout strobe.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
   typedef enum logic [2:0] {
      IV_SHORT,
      IV_TWO,
      IV_THREE,
      IV_FOUR,
      IV_GAP
   } iv_class_e;
endpackage

// File: rtl/fmd_gap_timer.sv
module fmd_gap_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] meas
);
   localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

   // Interval including the tick of the current cycle, saturating
   assign meas = (tick && cnt_q != SAT) ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (restart)  cnt_q <= '0;
      else               cnt_q <= meas;
   end
endmodule

// File: rtl/fmd_iv_class.sv
module fmd_iv_class
   import fmd_pkg::*;
#(
   parameter int CNT_W   = 9,
   parameter int T_TWO   = 25,
   parameter int T_THREE = 41,
   parameter int T_FOUR  = 57,
   parameter int T_GAP   = 80
) (
   input  logic [CNT_W-1:0] iv,
   output iv_class_e        cls
);
   always_comb begin
      if (iv >= CNT_W'(T_GAP))        cls = IV_GAP;
      else if (iv >= CNT_W'(T_FOUR))  cls = IV_FOUR;
      else if (iv >= CNT_W'(T_THREE)) cls = IV_THREE;
      else if (iv >= CNT_W'(T_TWO))   cls = IV_TWO;
      else                            cls = IV_SHORT;
   end
endmodule

// File: rtl/fmd_bit_packer.sv
module fmd_bit_packer #(
   parameter int MAX_BITS = 64,
   parameter int CW       = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic [1:0]          add_n,
   input  logic                bit_a,
   input  logic                bit_b,
   output logic [MAX_BITS-1:0] frame_bytes,
   output logic [CW-1:0]       bit_count
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;

   always_comb begin
      if (int'(cnt_q) + int'(add_n) >= MAX_BITS) cnt_nx = CW'(MAX_BITS);
      else                                       cnt_nx = cnt_q + CW'(add_n);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt_q <= '0;
      else                 cnt_q <= cnt_nx;
   end

   for (genvar k = 0; k < MAX_BITS; k++) begin : g_bit
      localparam int POS = (k / 8) * 8 + 7 - (k % 8);
      logic b_q;
      logic wr_a;
      logic wr_b;
      assign wr_a = (add_n != 2'd0) && (cnt_q == CW'(k));
      if (k == 0) begin : g_first
         assign wr_b = 1'b0;
      end else begin : g_rest
         assign wr_b = (add_n == 2'd2) && (cnt_q == CW'(k - 1));
      end
      always_ff @(posedge clk) begin
         if (!rst_n || clear) b_q <= 1'b0;
         else if (wr_a)       b_q <= bit_a;
         else if (wr_b)       b_q <= bit_b;
      end
      assign frame_bytes[POS] = b_q;
   end

   assign bit_count = cnt_q;
endmodule

// File: rtl/fe_manchester_rx.sv
module fe_manchester_rx
   import fmd_pkg::*;
#(
   parameter int MAX_BITS    = 64,
   parameter int HALF        = 16,
   parameter int T_TWO       = 25,
   parameter int T_THREE     = 41,
   parameter int T_FOUR      = 57,
   parameter int T_EOF       = 80,
   parameter int T_WINDOW    = 300,
   parameter int SOF_LONG    = 4,
   parameter int SOF_SHORT   = 1,
   parameter int SYNC_STAGES = 0,
   localparam int CW    = $clog2(MAX_BITS + 1),
   localparam int CNT_W = $clog2(T_WINDOW + 1),
   localparam int SOF_W = $clog2(SOF_LONG + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                t0_tick,
   input  logic                start,
   input  logic                sof_long,
   input  logic                rx_in,
   output logic [MAX_BITS-1:0] frame_bytes,
   output logic [CW-1:0]       bit_count,
   output logic [CNT_W-1:0]    resp_gap,
   output logic                last_bit,
   output logic                busy,
   output logic                done,
   output logic                timeout
);
   if (MAX_BITS % 8 != 0 || MAX_BITS < 8) begin : g_chk_bits
      $error("MAX_BITS must be a positive multiple of 8");
   end
   if (!(HALF < T_TWO && T_TWO < T_THREE && T_THREE < T_FOUR &&
         T_FOUR < T_EOF && T_EOF < T_WINDOW)) begin : g_chk_thr
      $error("interval thresholds must be strictly ascending");
   end
   if (SOF_SHORT > SOF_LONG || SOF_SHORT < 0) begin : g_chk_sof
      $error("SOF_SHORT must lie in 0..SOF_LONG");
   end

   // Input conditioning: optional synchroniser chosen by parameter
   logic rx_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rx_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[SYNC_STAGES-2+1-1:0], rx_in};
      end
      assign rx_s = sh_q[SYNC_STAGES-1];
   end

   logic rx_d;
   logic fall;
   always_ff @(posedge clk) begin
      if (!rst_n) rx_d <= 1'b0;
      else        rx_d <= rx_s;
   end
   assign fall = rx_d & ~rx_s;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] meas;
   fmd_gap_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (t0_tick),
      .restart(start | fall),
      .cnt_q  (cnt_q),
      .meas   (meas)
   );

   iv_class_e cls;
   fmd_iv_class #(
      .CNT_W(CNT_W), .T_TWO(T_TWO), .T_THREE(T_THREE),
      .T_FOUR(T_FOUR), .T_GAP(T_EOF)
   ) u_class (
      .iv (meas),
      .cls(cls)
   );

   logic             lb_q;
   logic             skip_q;
   logic [SOF_W-1:0] sof_q;
   logic             act;
   logic [1:0]       add_n;
   logic             bit_a;
   logic             bit_b;

   assign act = busy & fall & ~start;

   always_comb begin
      add_n = 2'd0;
      bit_a = 1'b0;
      bit_b = 1'b0;
      if (act) begin
         unique case (cls)
            IV_FOUR: begin
               add_n = 2'd2;
               bit_b = 1'b1;
            end
            IV_THREE: begin
               add_n = skip_q ? 2'd1 : 2'd2;
               bit_b = 1'b1;
            end
            IV_TWO: begin
               if (sof_q == '0) begin
                  add_n = 2'd1;
                  bit_a = lb_q;
               end
            end
            default: ;
         endcase
      end
   end

   fmd_bit_packer #(.MAX_BITS(MAX_BITS), .CW(CW)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start),
      .add_n      (add_n),
      .bit_a      (bit_a),
      .bit_b      (bit_b),
      .frame_bytes(frame_bytes),
      .bit_count  (bit_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         timeout  <= 1'b0;
         lb_q     <= 1'b1;
         skip_q   <= 1'b1;
         sof_q    <= '0;
         resp_gap <= '0;
      end else begin
         done    <= 1'b0;
         timeout <= 1'b0;
         if (start) begin
            busy     <= 1'b1;
            lb_q     <= 1'b1;
            skip_q   <= 1'b1;
            sof_q    <= sof_long ? SOF_W'(SOF_LONG) : SOF_W'(SOF_SHORT);
            resp_gap <= '0;
         end else if (busy) begin
            if (fall) begin
               unique case (cls)
                  IV_GAP:   resp_gap <= meas - CNT_W'(HALF);
                  IV_THREE: begin
                     lb_q   <= ~lb_q;
                     skip_q <= ~skip_q;
                  end
                  IV_TWO:   if (sof_q != '0) sof_q <= sof_q - 1'b1;
                  default: ;
               endcase
            end else if (bit_count != '0 && cnt_q >= CNT_W'(T_EOF)) begin
               done <= 1'b1;
               busy <= 1'b0;
            end else if (bit_count == '0 && cnt_q >= CNT_W'(T_WINDOW)) begin
               timeout <= 1'b1;
               busy    <= 1'b0;
            end
         end
      end
   end

   assign last_bit = lb_q;
endmodule

// File: rtl/fmd_checker.sv
module fmd_checker #(
   parameter int MAX_BITS = 64,
   parameter int CW       = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [CW-1:0] bit_count,
   input logic          last_bit,
   input logic          busy,
   input logic          done,
   input logic          timeout
);
   a_r8_done_has_bits: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> bit_count != '0);
   a_r9_timeout_empty: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> bit_count == '0);
   a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout));
   a_r8_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (done || timeout) |-> !busy);
   a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bit_count) <= MAX_BITS);
   a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (bit_count >= $past(bit_count)) &&
                 (int'(bit_count) <= int'($past(bit_count)) + 2));
   a_r7_start_init: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> last_bit && busy && bit_count == '0);
endmodule

bind fe_manchester_rx fmd_checker #(.MAX_BITS(MAX_BITS), .CW(CW)) u_fmd_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .bit_count(bit_count),
   .last_bit (last_bit),
   .busy     (busy),
   .done     (done),
   .timeout  (timeout)
);

// File: tb/fe_manchester_rx_bench.sv
module fe_manchester_rx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        t0_tick = 1'b1;
   logic        start = 1'b0;
   logic        sof_long = 1'b0;
   logic        rx_in = 1'b0;
   logic [63:0] frame_bytes;
   logic [6:0]  bit_count;
   logic [8:0]  resp_gap;
   logic        last_bit, busy, done, timeout;

   int n_checks = 0;
   int n_fail = 0;
   int mul = 1;
   bit half_rate = 1'b0;

   always #4 clk = ~clk;

   always @(negedge clk) t0_tick <= half_rate ? ~t0_tick : 1'b1;

   fe_manchester_rx u_fe_manchester_rx (
      .clk(clk), .rst_n(rst_n), .t0_tick(t0_tick), .start(start),
      .sof_long(sof_long), .rx_in(rx_in), .frame_bytes(frame_bytes),
      .bit_count(bit_count), .resp_gap(resp_gap), .last_bit(last_bit),
      .busy(busy), .done(done), .timeout(timeout)
   );

   // Bench model state, derived from the requirements
   bit          m_lb, m_skip;
   int          m_sof, m_cnt, m_resp;
   logic [63:0] m_bytes;

   task automatic check(string req, longint got, longint exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic push(bit b);
      if (m_cnt < 64) m_bytes[(m_cnt / 8) * 8 + 7 - (m_cnt % 8)] = b;
      if (m_cnt < 64) m_cnt++;
   endtask

   task automatic start_frame(bit sl);
      @(negedge clk);
      start = 1'b1; sof_long = sl; rx_in = 1'b0;
      @(negedge clk);
      start = 1'b0;
      m_lb = 1'b1; m_skip = 1'b1; m_sof = sl ? 4 : 1;
      m_cnt = 0; m_bytes = '0; m_resp = 0;
   endtask

   // Next falling edge v units after the previous one (or after start)
   task automatic edge_after(int v);
      rx_in = 1'b1;
      repeat (v * mul - 1) @(negedge clk);
      rx_in = 1'b0;
      @(negedge clk);
      if (v >= 80) m_resp = v - 16;
      else if (v >= 57) begin push(1'b0); push(1'b1); end
      else if (v >= 41) begin
         push(1'b0);
         if (!m_skip) push(1'b1);
         m_lb = ~m_lb; m_skip = ~m_skip;
      end else if (v >= 25) begin
         if (m_sof > 0) m_sof--;
         else push(m_lb);
      end
   endtask

   task automatic finish_run(string req);
      bit saw_done = 1'b0, saw_to = 1'b0;
      for (int i = 0; i < 1000 && !saw_done && !saw_to; i++) begin
         @(negedge clk);
         saw_done = done; saw_to = timeout;
      end
      check({req, " R8 done"}, saw_done, m_cnt > 0);
      check({req, " R9 timeout"}, saw_to, m_cnt == 0);
      check({req, " R10 count"}, bit_count, m_cnt);
      check({req, " R10 bytes"}, frame_bytes, m_bytes);
      check({req, " R2 resp"}, resp_gap, m_resp);
      check({req, " R11 last_bit"}, last_bit, m_lb);
      check({req, " R8 busy low"}, busy, 0);
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 190000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got %0d expected below 190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
         end
      end
   end

   initial begin
      int seq[3];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 count", bit_count, 0);
      check("R1 last_bit", last_bit, 1);
      check("R1 done", done, 0);
      check("R1 timeout", timeout, 0);

      // R9: nothing at all
      start_frame(1'b0);
      check("R7 busy after start", busy, 1);
      finish_run("R9 silent");

      // Sweep one interval after a gap: R3 R4 R5 R6 bands, R7 both modes
      for (int v = 2; v < 80; v++) begin
         start_frame(v[0]);
         edge_after(90);
         edge_after(v);
         finish_run($sformatf("R3/R4/R5/R6 single %0d", v));
      end

      // Every three-interval mix of the bit bands, both discard modes (R4 R5 R7)
      seq[0] = 30; seq[1] = 45; seq[2] = 60;
      for (int sl = 0; sl < 2; sl++)
         for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
               for (int c = 0; c < 3; c++) begin
                  start_frame(sl[0]);
                  edge_after(85);
                  edge_after(seq[a]);
                  edge_after(seq[b]);
                  edge_after(seq[c]);
                  finish_run($sformatf("R4/R5 mix %0d%0d%0d sl%0d", a, b, c, sl));
               end

      // R6: short interval mid-frame is ignored but restarts timing
      start_frame(1'b0);
      edge_after(100);
      edge_after(60);
      edge_after(20);
      edge_after(60);
      finish_run("R6 ignored short");

      // R10: long frame saturates at 64 bits
      start_frame(1'b1);
      edge_after(82);
      for (int i = 0; i < 40; i++) edge_after(60);
      finish_run("R10 saturate");

      // R12: half-rate tick, same decode
      half_rate = 1'b1; mul = 2;
      start_frame(1'b0);
      edge_after(95);
      edge_after(60);
      edge_after(45);
      edge_after(45);
      edge_after(30);
      finish_run("R12 half rate");
      start_frame(1'b1);
      finish_run("R12 half rate silent");

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule